// File: doc/BRIEF.md
# Display Prefetch Controller

At the start of each visible line, a raster video timing generator must fill the pixel shifter before pixels can be shown. This block starts that fill when the display-enable decision pulse arrives. It produces one word-load strobe for every four strobed clock cycles. It stops once enough 16-bit words are in, and the number of words depends on the resolution mode and on whether fine horizontal scroll is active. The stop test is made again at every word boundary with the mode present at that moment. A mode change during the fill therefore lengthens or shortens it. Software uses this to make lines longer than normal.

When the fill ends, the block sets a display-active flag, and an end-of-line pulse clears it. The block also has a combinational blank override. The override is high while high resolution is selected with a colour monitor, and it never acts when a monochrome monitor is fitted.

Top module: `vid_prefetch_ctl`

## Requirements
- R1: While `rst_n` is low, `pf_busy`, `disp_act` and `word_ld` are 0. The reset acts asynchronously and is released through a two-stage synchronizer.
- R2: If `de_start` is high on a strobed cycle (`cyc_en`=1) while idle, `pf_busy` is 1 from the next cycle on. `word_ld` is high on every fourth strobed busy cycle.
- R3: With `res_mode`=2 (high), the fill ends after 1 word, which is 4 strobed busy cycles. Fine scroll does not change this.
- R4: With `res_mode`=0 (low), or `res_mode`=1 (medium) with `fscroll_on`=0, or code 3, the fill ends after 4 words, which is 16 strobed busy cycles.
- R5: With `res_mode`=1 and `fscroll_on`=1, the fill ends after 2 words, which is 8 strobed busy cycles.
- R6: The stop test uses `res_mode` and `fscroll_on` as they are in the cycle of each word load. Switching from high to low before the first boundary extends the fill to 16 cycles. Switching from low to high after word k ends the fill at the next boundary.
- R7: The fill ends on the clock edge that closes a word load. On that edge `pf_busy` falls and `disp_act` rises.
- R8: On a strobed cycle, `eol_pulse` clears `disp_act`. If the fill ends on the same cycle, `disp_act` is set instead.
- R9: A `de_start` that arrives while busy is ignored, including on the cycle in which the fill ends.
- R10: While `cyc_en` is 0, the busy flag, the phase and the word count hold, and `word_ld` stays 0.
- R11: `blank_force` is 1 exactly when `res_mode`=2 and `mono_mon`=0, and it drops as soon as a lower resolution is selected.
- R12: With `mono_mon`=1, `blank_force` is 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Cycle strobe; state advances only when high |
| de_start | input | 1 | Display-enable decision pulse |
| res_mode | input | 2 | 0 low, 1 medium, 2 high, 3 treated as low |
| fscroll_on | input | 1 | Fine horizontal scroll active |
| mono_mon | input | 1 | 1 when a monochrome monitor is fitted |
| eol_pulse | input | 1 | End-of-line pulse, clears display-active |
| word_ld | output | 1 | Shifter word-load strobe |
| pf_busy | output | 1 | Prefetch in progress |
| disp_act | output | 1 | Horizontal display-active flag |
| blank_force | output | 1 | Blank override |

## Verification
Two events can land on the same cycle: the fill finishing on a word load, and either the end-of-line pulse or a fresh enable pulse. The bench provokes this by raising `eol_pulse` and `de_start` during the busy cycle that carries the final `word_ld`. It then checks that `disp_act` ends up set, that `pf_busy` ends up clear, and that no new fill starts. Mode switches are timed in the same way, just before and just after word boundaries, and the resulting fill lengths are judged by counting busy cycles.

// File: rtl/vpf_pkg.sv
package vpf_pkg;
  localparam int CYC_PER_WORD = 4;
  localparam int WORDS_FULL   = 4;
  localparam int WORDS_SCROLL = 2;
  localparam int WORDS_HIGH   = 1;
  localparam int PH_W = $clog2(CYC_PER_WORD);
  localparam int WC_W = $clog2(WORDS_FULL + 1);

  typedef enum logic [1:0] {
    RES_LOW  = 2'd0,
    RES_MED  = 2'd1,
    RES_HIGH = 2'd2,
    RES_RSV  = 2'd3
  } res_e;
endpackage

// File: rtl/vpf_rst_sync.sv
module vpf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/vpf_len_sel.sv
module vpf_len_sel
  import vpf_pkg::*;
(
  input  logic [1:0]      res_mode,
  input  logic            fscroll_on,
  output logic [WC_W-1:0] word_limit
);
  res_e res;

  always_comb begin
    res = res_e'(res_mode);
    unique case (res)
      RES_HIGH: word_limit = WC_W'(WORDS_HIGH);
      RES_MED:  word_limit = fscroll_on ? WC_W'(WORDS_SCROLL) : WC_W'(WORDS_FULL);
      default:  word_limit = WC_W'(WORDS_FULL);
    endcase
  end
endmodule

// File: rtl/vpf_seq.sv
module vpf_seq
  import vpf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_en,
  input  logic            de_start,
  input  logic            eol_pulse,
  input  logic [WC_W-1:0] word_limit,
  output logic            word_ld,
  output logic            pf_busy,
  output logic            disp_act
);
  logic            busy_q, busy_d;
  logic            act_q, act_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [WC_W-1:0] wc_q, wc_d;
  logic            boundary, finish, start;
  logic [WC_W-1:0] words_done;

  always_comb begin
    boundary   = busy_q && (ph_q == PH_W'(CYC_PER_WORD - 1));
    words_done = wc_q + WC_W'(1);
    finish     = boundary && (words_done >= word_limit);
    start      = de_start && !busy_q;

    busy_d = busy_q;
    ph_d   = ph_q;
    wc_d   = wc_q;
    act_d  = act_q;
    if (cyc_en) begin
      if (start) begin
        busy_d = 1'b1;
        ph_d   = '0;
        wc_d   = '0;
      end else if (busy_q) begin
        ph_d = boundary ? '0 : ph_q + PH_W'(1);
        if (boundary) wc_d = words_done;
        if (finish)   busy_d = 1'b0;
      end
      if (finish)         act_d = 1'b1;
      else if (eol_pulse) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      act_q  <= 1'b0;
      ph_q   <= '0;
      wc_q   <= '0;
    end else begin
      busy_q <= busy_d;
      act_q  <= act_d;
      ph_q   <= ph_d;
      wc_q   <= wc_d;
    end
  end

  assign word_ld  = cyc_en && boundary;
  assign pf_busy  = busy_q;
  assign disp_act = act_q;
endmodule

// File: rtl/vpf_blank.sv
module vpf_blank
  import vpf_pkg::*;
(
  input  logic [1:0] res_mode,
  input  logic       mono_mon,
  output logic       blank_force
);
  always_comb begin
    blank_force = (res_e'(res_mode) == RES_HIGH) && !mono_mon;
  end
endmodule

// File: rtl/vid_prefetch_ctl.sv
module vid_prefetch_ctl
  import vpf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_en,
  input  logic       de_start,
  input  logic [1:0] res_mode,
  input  logic       fscroll_on,
  input  logic       mono_mon,
  input  logic       eol_pulse,
  output logic       word_ld,
  output logic       pf_busy,
  output logic       disp_act,
  output logic       blank_force
);
  logic            rst_int_n;
  logic [WC_W-1:0] word_limit;

  vpf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  vpf_len_sel u_len (
    .res_mode   (res_mode),
    .fscroll_on (fscroll_on),
    .word_limit (word_limit)
  );

  vpf_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cyc_en     (cyc_en),
    .de_start   (de_start),
    .eol_pulse  (eol_pulse),
    .word_limit (word_limit),
    .word_ld    (word_ld),
    .pf_busy    (pf_busy),
    .disp_act   (disp_act)
  );

  vpf_blank u_blank (
    .res_mode    (res_mode),
    .mono_mon    (mono_mon),
    .blank_force (blank_force)
  );
endmodule

// File: rtl/vpf_checker.sv
module vpf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_en,
  input logic       de_start,
  input logic [1:0] res_mode,
  input logic       mono_mon,
  input logic       eol_pulse,
  input logic       word_ld,
  input logic       pf_busy,
  input logic       disp_act,
  input logic       blank_force
);
  AST_LD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    word_ld |-> pf_busy);                                          // R2
  AST_END_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pf_busy) |-> $past(word_ld));                            // R7
  AST_ACT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pf_busy) |-> disp_act);                                  // R7
  AST_EOL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && eol_pulse && !word_ld) |=> !disp_act);              // R8
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_en) |=> ($stable(pf_busy) && $stable(disp_act)));        // R10
  AST_NO_LD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_en) |-> !word_ld);                                       // R10
  AST_MONO_NO_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    mono_mon |-> !blank_force);                                    // R12
  AST_BLANK_HIGH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    blank_force |-> (res_mode == 2'd2));                           // R11
endmodule

bind vid_prefetch_ctl vpf_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cyc_en      (cyc_en),
  .de_start    (de_start),
  .res_mode    (res_mode),
  .mono_mon    (mono_mon),
  .eol_pulse   (eol_pulse),
  .word_ld     (word_ld),
  .pf_busy     (pf_busy),
  .disp_act    (disp_act),
  .blank_force (blank_force)
);

// File: tb/sim_vid_prefetch_ctl.sv
module sim_vid_prefetch_ctl;
  logic clk = 1'b0;
  logic rst_n, cyc_en, de_start, fscroll_on, mono_mon, eol_pulse;
  logic [1:0] res_mode;
  logic word_ld, pf_busy, disp_act, blank_force;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  vid_prefetch_ctl u0 (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .de_start(de_start),
    .res_mode(res_mode), .fscroll_on(fscroll_on), .mono_mon(mono_mon),
    .eol_pulse(eol_pulse), .word_ld(word_ld), .pf_busy(pf_busy),
    .disp_act(disp_act), .blank_force(blank_force)
  );

  // {res(2), scroll(1), switch_after(8), new_res(2), exp_len(8)}
  localparam int NV = 9;
  localparam logic [20:0] VEC [NV] = '{
    {2'd2, 1'b0, 8'd0, 2'd2, 8'd4},   // R3
    {2'd2, 1'b1, 8'd0, 2'd2, 8'd4},   // R3
    {2'd0, 1'b0, 8'd0, 2'd0, 8'd16},  // R4
    {2'd1, 1'b0, 8'd0, 2'd1, 8'd16},  // R4
    {2'd1, 1'b1, 8'd0, 2'd1, 8'd8},   // R5
    {2'd2, 1'b0, 8'd2, 2'd0, 8'd16},  // R6 high->low before boundary
    {2'd0, 1'b0, 8'd5, 2'd2, 8'd8},   // R6 low->high after word 1
    {2'd0, 1'b0, 8'd9, 2'd2, 8'd12},  // R6 low->high after word 2
    {2'd1, 1'b1, 8'd2, 2'd2, 8'd4}    // R6 med scroll->high
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr_line();
    eol_pulse = 1'b1;
    @(negedge clk);
    eol_pulse = 1'b0;
  endtask

  task automatic fire();
    de_start = 1'b1;
    @(negedge clk);
    de_start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt, lds;
    rst_n = 1'b0; cyc_en = 1'b1; de_start = 1'b0; fscroll_on = 1'b0;
    mono_mon = 1'b0; eol_pulse = 1'b0; res_mode = 2'd0;
    repeat (3) @(negedge clk);
    check(!pf_busy && !disp_act && !word_ld, "R1 reset outputs", {pf_busy, disp_act, word_ld}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      res_mode = VEC[v][20:19]; fscroll_on = VEC[v][18];
      clr_line();
      check(!disp_act, "R8 eol clears", disp_act, 0);
      fire();
      check(pf_busy, "R2 busy after start", pf_busy, 1);
      cnt = 0; lds = 0;
      while (pf_busy && cnt < 100) begin
        cnt++;
        if (word_ld) lds++;
        if (cnt == int'(VEC[v][17:10])) res_mode = VEC[v][9:8];
        @(negedge clk);
      end
      check(cnt == int'(VEC[v][7:0]), "R3/R4/R5/R6 fill length", cnt, int'(VEC[v][7:0]));
      check(lds == int'(VEC[v][7:0]) / 4, "R2 word loads", lds, int'(VEC[v][7:0]) / 4);
      check(disp_act, "R7 active after fill", disp_act, 1);
    end

    // R9: enable pulse mid-fill ignored
    res_mode = 2'd0; fscroll_on = 1'b0;
    clr_line();
    fire();
    cnt = 0;
    while (pf_busy && cnt < 100) begin
      cnt++;
      de_start = (cnt == 3);
      @(negedge clk);
    end
    de_start = 1'b0;
    check(cnt == 16, "R9 restart ignored", cnt, 16);

    // R8/R9: end-of-line and new enable on the final load cycle
    res_mode = 2'd2;
    clr_line();
    fire();
    repeat (3) @(negedge clk);
    check(word_ld, "R2 final load cycle", word_ld, 1);
    eol_pulse = 1'b1; de_start = 1'b1;
    @(negedge clk);
    eol_pulse = 1'b0; de_start = 1'b0;
    check(disp_act, "R8 end wins over eol", disp_act, 1);
    check(!pf_busy, "R9 enable on end cycle ignored", pf_busy, 0);

    // R10: strobe low freezes
    res_mode = 2'd0;
    clr_line();
    fire();
    @(negedge clk);
    cyc_en = 1'b0;
    lds = 0;
    for (int k = 0; k < 6; k++) begin
      if (word_ld || !pf_busy) lds++;
      @(negedge clk);
    end
    check(lds == 0, "R10 frozen while strobe low", lds, 0);
    cyc_en = 1'b1;
    cnt = 1;
    while (pf_busy && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == 16, "R10 strobed length kept", cnt, 16);

    // R11/R12 blank override
    mono_mon = 1'b0; res_mode = 2'd2; #1;
    check(blank_force, "R11 high colour blanks", blank_force, 1);
    res_mode = 2'd0; #1;
    check(!blank_force, "R11 clears on low", blank_force, 0);
    res_mode = 2'd1; #1;
    check(!blank_force, "R11 clears on medium", blank_force, 0);
    mono_mon = 1'b1; res_mode = 2'd2; #1;
    check(!blank_force, "R12 mono no blank", blank_force, 0);
    mono_mon = 1'b0;
    @(negedge clk);

    // R1: asynchronous reset mid-fill
    res_mode = 2'd0;
    fire();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!pf_busy && !disp_act && !word_ld, "R1 async reset", {pf_busy, disp_act, word_ld}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fire();
    check(!pf_busy, "R1 held during sync release", pf_busy, 0);
    repeat (2) @(negedge clk);
    fire();
    check(pf_busy, "R2 starts after release", pf_busy, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule